// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This coprocessor turns one 8x8 block of signed pixels into 64 forward DCT coefficients. It works in integer arithmetic where 64 stands for 1.0, so six bits are fractional. A host sees four byte-wide registers on a small polled bus. It writes 64 pixels into the pixel port and then writes the value 1 to the command port. It polls the status port until the engine goes idle, and then reads each 16-bit coefficient from the coefficient port as two bytes.

Inside, a single multiplier and one accumulator run two passes. The first pass forms the row sums for every pixel row and frequency pair and keeps them in an intermediate buffer. The second pass combines those sums down the columns, applies the normalisation scaling and writes the coefficient buffer. The cosine constants are computed from nine magnitudes rather than stored as a full table.

Top module: `fdct_coproc`

## Requirements
- R1: After reset, rdData is 0, and a status read (regAddr 3) returns 0.
- R2: Each write to regAddr 0 while idle stores wrData as a signed 8-bit pixel, scaled by 64, at the next position of a row-major push index (index = row*8 + column). The index wraps from 63 to 0, so a 65th push overwrites pixel 0.
- R3: A write of exactly 8'h01 to regAddr 2 while idle starts a transform, and status reads return 1 from the next cycle on. A write of any other value to regAddr 2 starts nothing.
- R4: The coefficient at row u and column v equals ((r*K) >>> 18) truncated to 16 bits. Here s[x] = sum over j of (P[x][j]*64*c(j,v)) >>> 6, and r = sum over x of (s[x]*c(x,u)) >>> 6. The scale is K = ((16*Cu) >>> 6)*Cv, with Cu and Cv equal to 45 for index 0 and 64 otherwise. The constant c(i,k) is 64*cos((2i+1)k*pi/16) with its magnitude truncated, which gives the magnitudes 64, 62, 59, 53, 45, 35, 24 and 12. All shifts are arithmetic.
- R5: Reads of regAddr 1 while idle return the coefficients in order u*8+v, upper byte first, 128 reads per block. The read position returns to coefficient 0, upper byte, when a transform completes.
- R6: While a transform runs, pixel writes, command writes and coefficient reads have no effect, and a coefficient read returns 0.
- R7: Status returns to 0 exactly 1152 clock cycles after the edge that accepts the start command.
- R8: The pixel push index returns to 0 when a transform completes.
- R9: Reads of regAddr 0 or regAddr 2 return 0. Every read result appears on rdData one clock after the cycle in which rdEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regAddr | input | 2 | Register select: 0 pixel in, 1 coefficient out, 2 command, 3 status |
| wrEn | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe, one cycle per access |
| rdData | output | 8 | Read data, valid the cycle after rdEn |

## Verification
The assertions take for granted that each access is a one-cycle strobe, that wrEn and rdEn are never high together, and that the host does not keep a start command asserted across cycles. The stimulus uses tasks that raise exactly one strobe for one cycle with an idle cycle after it. Pixel values come from $urandom with a fixed seed, mixed with directed blocks at both ends of the signed range and an alternating pattern. Accesses made while busy are issued only through those same single-cycle tasks, so the busy-cycle counter in the checker sees a clean start edge.

// File: rtl/fdct_pkg.sv
package fdct_pkg;
  localparam int N      = 8;
  localparam int NN     = N * N;
  localparam int PIX_W  = 8;
  localparam int COEF_W = 16;
  localparam int FRAC   = 6;
  localparam int ACC_W  = 32;
  localparam int CST_W  = 8;
  localparam int IDX_W  = $clog2(NN);
  localparam int K_W    = $clog2(N);
  localparam int BUSY_CYCLES = 2 * NN * (N + 1);
  localparam int C0_Q   = 45;   // 1/sqrt(2) in Q6
  localparam int ONE_Q  = 64;   // 1.0 in Q6
  localparam int QTR_Q  = 16;   // 1/4 in Q6

  typedef enum logic [1:0] {
    REG_PIX  = 2'd0,
    REG_COEF = 2'd1,
    REG_CMD  = 2'd2,
    REG_STAT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             macEn;
    logic             macFirst;
    logic             colPass;
    logic             wrS;
    logic             wrOut;
    logic [K_W-1:0]   k;
    logic [K_W-1:0]   rowSel;
    logic [K_W-1:0]   colSel;
    logic             pixWr;
    logic [IDX_W-1:0] pushIdx;
    logic             popRd;
    logic [IDX_W:0]   popPtr;
    logic             statRd;
    logic             otherRd;
  } dpCtl_t;

  // Q6 cosine of (2i+1)*k*pi/16, folded onto nine magnitudes
  function automatic logic signed [CST_W-1:0] cosQ(input logic [K_W-1:0] i,
                                                   input logic [K_W-1:0] k);
    logic [7:0] prod;
    logic [4:0] m;
    logic [3:0] f;
    logic signed [CST_W-1:0] mag;
    prod = ({4'd0, i, 1'b1}) * ({5'd0, k});
    m    = prod[4:0];
    f    = (m > 5'd16) ? 4'(6'd32 - {1'b0, m}) : 4'(m);
    if (f > 4'd8) f = 4'(5'd16 - {1'b0, f});
    case (f)
      4'd0:    mag = 8'sd64;
      4'd1:    mag = 8'sd62;
      4'd2:    mag = 8'sd59;
      4'd3:    mag = 8'sd53;
      4'd4:    mag = 8'sd45;
      4'd5:    mag = 8'sd35;
      4'd6:    mag = 8'sd24;
      4'd7:    mag = 8'sd12;
      default: mag = 8'sd0;
    endcase
    begin
      logic [4:0] mf;
      mf = (m > 5'd16) ? 5'(6'd32 - {1'b0, m}) : m;
      return (mf > 5'd8) ? -mag : mag;
    end
  endfunction
endpackage

// File: rtl/fdct_ctrl.sv
module fdct_ctrl
  import fdct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] regAddr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output dpCtl_t     ctl,
  output logic       busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_WR} state_e;

  state_e           state;
  logic [K_W-1:0]   kCnt;
  logic [IDX_W-1:0] elem;
  logic             colPass;
  logic [IDX_W-1:0] pushIdx;
  logic [IDX_W:0]   popPtr;
  logic             pixWr, popRd, statRd, startCmd;

  assign busy     = (state != ST_IDLE);
  assign pixWr    = wrEn && (regAddr == REG_PIX) && !busy;
  assign popRd    = rdEn && (regAddr == REG_COEF) && !busy;
  assign statRd   = rdEn && (regAddr == REG_STAT);
  assign startCmd = wrEn && (regAddr == REG_CMD) && (wrData == 8'd1) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kCnt    <= '0;
      elem    <= '0;
      colPass <= 1'b0;
      pushIdx <= '0;
      popPtr  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pixWr) pushIdx <= pushIdx + 1'b1;
          if (popRd) popPtr  <= popPtr + 1'b1;
          if (startCmd) begin
            state   <= ST_MAC;
            kCnt    <= '0;
            elem    <= '0;
            colPass <= 1'b0;
          end
        end
        ST_MAC: begin
          kCnt <= kCnt + 1'b1;
          if (kCnt == K_W'(N - 1)) state <= ST_WR;
        end
        default: begin
          elem  <= elem + 1'b1;
          state <= ST_MAC;
          if (elem == IDX_W'(NN - 1)) begin
            if (colPass) begin
              state   <= ST_IDLE;
              pushIdx <= '0;
              popPtr  <= '0;
            end else begin
              colPass <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.macEn    = (state == ST_MAC);
    ctl.macFirst = (kCnt == '0);
    ctl.colPass  = colPass;
    ctl.wrS      = (state == ST_WR) && !colPass;
    ctl.wrOut    = (state == ST_WR) && colPass;
    ctl.k        = kCnt;
    ctl.rowSel   = elem[IDX_W-1:K_W];
    ctl.colSel   = elem[K_W-1:0];
    ctl.pixWr    = pixWr;
    ctl.pushIdx  = pushIdx;
    ctl.popRd    = popRd;
    ctl.popPtr   = popPtr;
    ctl.statRd   = statRd;
    ctl.otherRd  = rdEn && !popRd && !statRd;
  end
endmodule

// File: rtl/fdct_datapath.sv
module fdct_datapath
  import fdct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpCtl_t     ctl,
  input  logic [7:0] wrData,
  input  logic       busy,
  output logic [7:0] rdData
);
  localparam int PROD_W  = ACC_W + CST_W;
  localparam int SCL_W   = ACC_W + COEF_W;
  localparam int SCL_SH  = 3 * FRAC;

  logic signed [COEF_W-1:0] imgBuf [NN];
  logic signed [ACC_W-1:0]  sBuf   [NN];
  logic signed [COEF_W-1:0] outBuf [NN];
  logic signed [ACC_W-1:0]  acc;

  logic signed [ACC_W-1:0]  opnd;
  logic signed [CST_W-1:0]  cst;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  term;
  logic signed [COEF_W-1:0] kScale;
  logic signed [SCL_W-1:0]  scaled;
  logic signed [COEF_W-1:0] coefOut;
  logic signed [COEF_W-1:0] pixQ;
  logic [IDX_W-1:0]         elemIdx;
  logic [COEF_W-1:0]        popWord;

  assign elemIdx = {ctl.rowSel, ctl.colSel};
  assign pixQ    = COEF_W'(signed'(wrData)) <<< FRAC;

  always_comb begin
    int cu, cv;
    if (ctl.colPass) begin
      opnd = sBuf[{ctl.k, ctl.colSel}];
      cst  = cosQ(ctl.k, ctl.rowSel);
    end else begin
      opnd = ACC_W'(imgBuf[{ctl.rowSel, ctl.k}]);
      cst  = cosQ(ctl.k, ctl.colSel);
    end
    prod    = PROD_W'(opnd) * PROD_W'(cst);
    term    = prod[FRAC+ACC_W-1:FRAC];
    cu      = (ctl.rowSel == '0) ? C0_Q : ONE_Q;
    cv      = (ctl.colSel == '0) ? C0_Q : ONE_Q;
    kScale  = COEF_W'(((QTR_Q * cu) >>> FRAC) * cv);
    scaled  = SCL_W'(acc) * SCL_W'(kScale);
    coefOut = scaled[SCL_SH+COEF_W-1:SCL_SH];
  end

  assign popWord = outBuf[ctl.popPtr[IDX_W:1]];

  always_ff @(posedge clk) begin
    if (ctl.macEn) acc <= ctl.macFirst ? term : acc + term;
    if (ctl.wrS)   sBuf[elemIdx]   <= acc;
    if (ctl.wrOut) outBuf[elemIdx] <= coefOut;
    if (ctl.pixWr) imgBuf[ctl.pushIdx] <= pixQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (ctl.statRd) begin
      rdData <= {7'd0, busy};
    end else if (ctl.popRd) begin
      rdData <= ctl.popPtr[0] ? popWord[7:0] : popWord[15:8];
    end else if (ctl.otherRd) begin
      rdData <= '0;
    end
  end
endmodule

// File: rtl/fdct_coproc.sv
module fdct_coproc
  import fdct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] regAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output logic [7:0] rdData
);
  dpCtl_t ctl;
  logic   busy;

  fdct_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .regAddr (regAddr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .wrData  (wrData),
    .ctl     (ctl),
    .busy    (busy)
  );

  fdct_datapath i_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .wrData (wrData),
    .busy   (busy),
    .rdData (rdData)
  );
endmodule

// File: rtl/fdct_coproc_chk.sv
module fdct_coproc_chk
  import fdct_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] regAddr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES) + 1;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst)       busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 2'd2 && wrData == 8'd1 && !busy) |=> busy);

  a_r3_other_value: assert property (@(posedge clk) disable iff (rst)
    (wrEn && regAddr == 2'd2 && wrData != 8'd1 && !busy) |=> !busy);

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && busyCnt < CNT_W'(BUSY_CYCLES - 1)) |=> busy);

  a_r7_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && busyCnt == CNT_W'(BUSY_CYCLES - 1)) |=> !busy);

  a_r6_pop_blocked: assert property (@(posedge clk) disable iff (rst)
    (rdEn && regAddr == 2'd1 && busy) |=> (rdData == 8'd0));

  a_r9_blank_reads: assert property (@(posedge clk) disable iff (rst)
    (rdEn && (regAddr == 2'd0 || regAddr == 2'd2)) |=> (rdData == 8'd0));

  a_r1_status_form: assert property (@(posedge clk) disable iff (rst)
    (rdEn && regAddr == 2'd3) |=> (rdData[7:1] == 7'd0));
endmodule

bind fdct_coproc fdct_coproc_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .regAddr (regAddr),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdEn    (rdEn),
  .rdData  (rdData),
  .busy    (busy)
);

// File: tb/test_fdct_coproc.sv
module test_fdct_coproc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] regAddr = 2'd0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  int pix  [64];
  int expc [64];

  always #5 clk = ~clk;

  fdct_coproc i_fdct_coproc (
    .clk(clk), .rst(rst), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  function automatic int cosRef(int i, int k);
    real v, a;
    int t;
    v = 64.0 * $cos(real'((2 * i + 1) * k) * 3.141592653589793 / 16.0);
    a = (v < 0.0) ? -v : v;
    t = int'($floor(a + 1.0e-9));
    return (v < 0.0) ? -t : t;
  endfunction

  // R4 expected coefficients
  function automatic void model();
    for (int u = 0; u < 8; u++) begin
      for (int v = 0; v < 8; v++) begin
        longint r = 0;
        longint kf, val;
        int cu, cv;
        logic signed [15:0] t16;
        for (int x = 0; x < 8; x++) begin
          longint s = 0;
          for (int j = 0; j < 8; j++)
            s += (longint'(pix[x*8+j] * 64) * cosRef(j, v)) >>> 6;
          r += (s * cosRef(x, u)) >>> 6;
        end
        cu  = (u == 0) ? 45 : 64;
        cv  = (v == 0) ? 45 : 64;
        kf  = longint'(((16 * cu) >>> 6) * cv);
        val = (r * kf) >>> 18;
        t16 = val[15:0];
        expc[u*8+v] = int'(t16);
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic pushBlock();
    for (int i = 0; i < 64; i++) wrReg(2'd0, 8'(pix[i]));
  endtask

  task automatic waitDone();
    logic [7:0] st;
    int n = 0;
    do begin
      rdReg(2'd3, st);
      n++;
    end while (st != 8'd0 && n < 5000);
  endtask

  task automatic popCheck(input string tag);
    logic [7:0] hi, lo;
    logic signed [15:0] w;
    for (int i = 0; i < 64; i++) begin
      rdReg(2'd1, hi);
      rdReg(2'd1, lo);
      w = {hi, lo};
      check(int'(w) == expc[i], tag, int'(w), expc[i]);
    end
  endtask

  task automatic randBlock();
    for (int i = 0; i < 64; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      pix[i] = int'($signed(b));
    end
  endtask

  task automatic runBlock(input string tag);
    pushBlock();
    model();
    wrReg(2'd2, 8'd1);
    waitDone();
    popCheck(tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd7219));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(rdData == 8'd0, "R1 rdData after reset", int'(rdData), 0);
    rdReg(2'd3, d); check(d == 8'd0, "R1 status after reset", int'(d), 0);
    // R9 blank addresses
    rdReg(2'd0, d); check(d == 8'd0, "R9 read pixel port", int'(d), 0);
    rdReg(2'd2, d); check(d == 8'd0, "R9 read command port", int'(d), 0);
    // R3 non-one command ignored
    wrReg(2'd2, 8'h02); rdReg(2'd3, d); check(d == 8'd0, "R3 cmd 0x02 ignored", int'(d), 0);
    wrReg(2'd2, 8'h81); rdReg(2'd3, d); check(d == 8'd0, "R3 cmd 0x81 ignored", int'(d), 0);

    // R4 directed blocks
    for (int i = 0; i < 64; i++) pix[i] = 10;
    runBlock("R4 constant");
    for (int i = 0; i < 64; i++) pix[i] = -128;
    runBlock("R4 all min");
    for (int i = 0; i < 64; i++) pix[i] = 127;
    runBlock("R4 all max");
    for (int i = 0; i < 64; i++) pix[i] = (((i >> 3) + i) % 2 == 0) ? 127 : -128;
    runBlock("R4 checkerboard");
    for (int i = 0; i < 64; i++) pix[i] = i - 32;
    runBlock("R4 ramp");

    // R7 exact busy length, R3 status goes high
    randBlock(); pushBlock(); model();
    wrReg(2'd2, 8'd1);
    regAddr = 2'd3; rdEn = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (n == 0) check(rdData == 8'd1, "R3 status busy after start", int'(rdData), 1);
      if (rdData != 8'd1 || n > 3000) break;
      n++;
    end
    rdEn = 1'b0;
    check(n == 1152, "R7 busy cycles", n, 1152);
    popCheck("R7 block result");

    // R6 accesses while busy
    randBlock(); pushBlock(); model();
    wrReg(2'd2, 8'd1);
    rdReg(2'd1, d); check(d == 8'd0, "R6 pop while busy", int'(d), 0);
    wrReg(2'd0, 8'h55); wrReg(2'd0, 8'hAA); wrReg(2'd0, 8'h11);
    wrReg(2'd2, 8'd1);
    waitDone();
    popCheck("R6 result after busy accesses");
    wrReg(2'd2, 8'd1);
    waitDone();
    popCheck("R6 pixels untouched by busy pushes");

    // R2 push wrap: 65th push overwrites pixel 0
    randBlock(); pushBlock();
    wrReg(2'd0, 8'h7F);
    pix[0] = 127;
    model();
    wrReg(2'd2, 8'd1);
    waitDone();
    popCheck("R2 push wrap");

    // R5 / R8 index restarts after completion
    for (int i = 0; i < 10; i++) rdReg(2'd1, d);
    randBlock();
    runBlock("R5 R8 indices restart");

    // R4 random blocks
    for (int b = 0; b < 6; b++) begin
      randBlock();
      runBlock("R4 random");
    end

    finishRun();
  end
endmodule